// File: doc/BRIEF.md
# Serial Flash Secure-Region Access Controller

This block sits in the command path of a serial NOR flash slave. It collects the opcode byte that the host shifts in on `si` while `cs_n` is low. For every complete opcode it returns one verdict, accept or reject. The verdict depends on the current access mode, the customer lock-down state and the array busy flag. Commands the filter admits go on to the array as a registered opcode with an accept pulse. The block also drives `otp_space`, which routes reads and programs either to the main array or to a separate 4K-bit one-time-programmable region.

The block holds an 8-bit security register with two meaningful bits. Bit 0 is a factory-lock indicator. It is loaded from a strap during reset and no command can write it. Bit 1 is a customer lock-down bit. A write-security command sets it, and no command ever clears it. Once that bit is set, the secure region accepts only read-type and mode-switch commands. A read-security command can be issued at any time, including while the array reports busy. It streams the register on `so`, most significant bit first, over and over until chip select rises.

Top module: `sfsec_ctrl`

## Requirements
- R1: Reset (synchronous, `rst_n` low) does the following. It clears `cmd_accept`, `cmd_reject`, `otp_space`, `so` and the lock-down bit. It copies `factory_strap` into security register bit 0.
- R2: The mode opcodes set `otp_space`. An accepted 0xB1 sets it to 1 (secure region). An accepted 0xC1 sets it to 0 (main array). No other event changes it.
- R3: A frame in which `cs_n` rises before eight opcode bits have been sampled produces no verdict and changes no state.
- R4: In the secure region with the lock-down bit clear, the following opcodes are rejected: 0x01 write status, 0x2F write security, 0x68 protect-mode select, 0x36/0x39 block lock/unlock, 0x7E/0x98 global lock/unlock, 0xC7 chip erase, 0xD8 block erase, 0x20 sector erase and 0x52 32K erase. All other known opcodes are accepted.
- R5: An accepted 0x2F sets security register bit 1. Only reset clears it again.
- R6: In the secure region with the lock-down bit set, only the following are accepted: the read-type opcodes 0x03 read, 0x0B fast read, 0x05 read status, 0x9F read ID and 0x2B read security, plus 0xB1 and 0xC1. Program 0x02 and write enable 0x06 are rejected.
- R7: While `array_busy` is high at the opcode's last bit, only 0x2B and 0x05 are accepted.
- R8: An accepted 0x2B drives the security register on `so`, MSB first, one bit per clock, repeating every 8 clocks while `cs_n` stays low. In the register, bit 0 is factory lock, bit 1 is lock-down and the other bits are 0. `so` is 0 whenever the register is not being streamed.
- R9: Each complete opcode raises exactly one of `cmd_accept` or `cmd_reject` for a single cycle, with the opcode on `cmd_op`.
- R10: Opcodes outside the set listed in R4 and R6 (plus 0x02, 0x06) are rejected in every mode.
- R11: Bits that follow the opcode in the same frame produce no further verdict.
- R12: In main-array mode with the array idle, every known opcode is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `si` is sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| factory_strap | input | 1 | Factory-lock value loaded during reset |
| cs_n | input | 1 | Active-low chip select framing each command |
| si | input | 1 | Serial opcode input, MSB first |
| array_busy | input | 1 | Array program/erase/write in progress |
| cmd_accept | output | 1 | One-cycle pulse: opcode admitted |
| cmd_reject | output | 1 | One-cycle pulse: opcode refused |
| cmd_op | output | 8 | Opcode of the latest verdict |
| otp_space | output | 1 | 1 = secure OTP region, 0 = main array |
| so | output | 1 | Serial security register data |

## Verification
The verdict pulse, `cmd_op` and any change of `otp_space` or of the lock-down bit all appear one cycle after the rising edge that samples the eighth opcode bit. The pulse drops again one cycle later. The MSB of the security register is on `so` in that same cycle, and each later edge with `cs_n` low advances the stream by one bit. The bench changes inputs on falling edges. It samples at the falling edge that follows the edge of interest, so every check lands in the cycle its result is due.

// File: rtl/sfsec_pkg.sv
// sfsec_pkg: opcode encodings, security register layout and the
// opcode classification shared by the controller and its checker.
package sfsec_pkg;

    localparam int OP_W     = 8;
    localparam int SECR_W   = 8;
    localparam int FACT_BIT = 0;
    localparam int LOCK_BIT = 1;

    localparam logic [OP_W-1:0] OPC_READ      = 8'h03;
    localparam logic [OP_W-1:0] OPC_FREAD     = 8'h0B;
    localparam logic [OP_W-1:0] OPC_STAT_RD   = 8'h05;
    localparam logic [OP_W-1:0] OPC_ID_RD     = 8'h9F;
    localparam logic [OP_W-1:0] OPC_SECREG_RD = 8'h2B;
    localparam logic [OP_W-1:0] OPC_PROG      = 8'h02;
    localparam logic [OP_W-1:0] OPC_WR_EN     = 8'h06;
    localparam logic [OP_W-1:0] OPC_STAT_WR   = 8'h01;
    localparam logic [OP_W-1:0] OPC_SECREG_WR = 8'h2F;
    localparam logic [OP_W-1:0] OPC_PROT_SEL  = 8'h68;
    localparam logic [OP_W-1:0] OPC_BLK_LOCK  = 8'h36;
    localparam logic [OP_W-1:0] OPC_BLK_FREE  = 8'h39;
    localparam logic [OP_W-1:0] OPC_ALL_LOCK  = 8'h7E;
    localparam logic [OP_W-1:0] OPC_ALL_FREE  = 8'h98;
    localparam logic [OP_W-1:0] OPC_ERASE_CHP = 8'hC7;
    localparam logic [OP_W-1:0] OPC_ERASE_64K = 8'hD8;
    localparam logic [OP_W-1:0] OPC_ERASE_4K  = 8'h20;
    localparam logic [OP_W-1:0] OPC_ERASE_32K = 8'h52;
    localparam logic [OP_W-1:0] OPC_OTP_ENTER = 8'hB1;
    localparam logic [OP_W-1:0] OPC_OTP_LEAVE = 8'hC1;

    typedef enum logic [2:0] {
        CLS_READ,   // read-type, allowed in every mode
        CLS_PROG,   // array write, barred once locked
        CLS_PROT,   // protection / erase, barred in secure region
        CLS_MODE,   // region switch
        CLS_BAD     // unknown opcode
    } op_class_e;

    // Sort an opcode into its filter class.
    function automatic op_class_e classify(input logic [OP_W-1:0] op);
        case (op)
            OPC_READ, OPC_FREAD, OPC_STAT_RD, OPC_ID_RD, OPC_SECREG_RD:
                return CLS_READ;
            OPC_PROG, OPC_WR_EN:
                return CLS_PROG;
            OPC_STAT_WR, OPC_SECREG_WR, OPC_PROT_SEL, OPC_BLK_LOCK,
            OPC_BLK_FREE, OPC_ALL_LOCK, OPC_ALL_FREE, OPC_ERASE_CHP,
            OPC_ERASE_64K, OPC_ERASE_4K, OPC_ERASE_32K:
                return CLS_PROT;
            OPC_OTP_ENTER, OPC_OTP_LEAVE:
                return CLS_MODE;
            default:
                return CLS_BAD;
        endcase
    endfunction

endpackage

// File: rtl/sfsec_deser.sv
// sfsec_deser: gathers the first OP_W bits of each chip-select frame.
// Assumes si is valid at every rising edge with cs_n low, MSB first.
// op_done is high in the cycle the last opcode bit is sampled; later
// bits of the same frame are ignored until cs_n rises.
module sfsec_deser #(
    parameter int OP_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            si,
    output logic            op_done,
    output logic [OP_W-1:0] op_word
);
    localparam int CNT_W = $clog2(OP_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OP_W - 1);

    logic [OP_W-2:0]  sh_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q;

    // Final opcode is the stored bits plus the bit on the wire now.
    assign op_word = {sh_q, si};
    assign op_done = !cs_n && !done_q && (cnt_q == LAST);

    // Shift opcode bits and track the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (cs_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            sh_q <= {sh_q[OP_W-3:0], si};
            if (cnt_q == LAST) begin
                cnt_q  <= '0;
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sfsec_filter.sv
// sfsec_filter: combinational admit/refuse decision for one opcode.
// Assumes the mode and lock inputs are the state before this opcode.
module sfsec_filter
    import sfsec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic            in_otp,
    input  logic            locked,
    input  logic            busy,
    output logic            allow
);
    op_class_e cls;

    // Decide from class, busy flag, region and lock state.
    always_comb begin
        cls = classify(op);
        if (cls == CLS_BAD)
            allow = 1'b0;
        else if (busy)
            allow = (op == OPC_SECREG_RD) || (op == OPC_STAT_RD);
        else if (!in_otp)
            allow = 1'b1;
        else if (!locked)
            allow = (cls != CLS_PROT);
        else
            allow = (cls == CLS_READ) || (cls == CLS_MODE);
    end

endmodule

// File: rtl/sfsec_secout.sv
// sfsec_secout: streams a register value on so, MSB first, rotating
// so the value repeats every REG_W clocks while cs_n stays low.
// Assumes load arrives in the cycle the read opcode completes.
module sfsec_secout #(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             load,
    input  logic [REG_W-1:0] value,
    output logic             so
);
    logic [REG_W-1:0] sh_q;
    logic             en_q;

    assign so = en_q & sh_q[REG_W-1];

    // Load, rotate, or drop the stream when the frame ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (cs_n) begin
            sh_q <= '0;
            en_q <= 1'b0;
        end else if (load) begin
            sh_q <= value;
            en_q <= 1'b1;
        end else if (en_q) begin
            sh_q <= {sh_q[REG_W-2:0], sh_q[REG_W-1]};
        end
    end

endmodule

// File: rtl/sfsec_ctrl.sv
// sfsec_ctrl: secure-region access controller. Deserializes opcodes,
// filters them by mode, lock and busy state, tracks the region select
// and the security register, and streams that register on request.
// Assumes one si bit per clock while cs_n is low.
module sfsec_ctrl
    import sfsec_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            factory_strap,
    input  logic            cs_n,
    input  logic            si,
    input  logic            array_busy,
    output logic            cmd_accept,
    output logic            cmd_reject,
    output logic [OP_W-1:0] cmd_op,
    output logic            otp_space,
    output logic            so
);
    logic              op_done;
    logic [OP_W-1:0]   op_word;
    logic              allow;
    logic              otp_q, lock_q, fact_q;
    logic              acc_q, rej_q;
    logic [OP_W-1:0]   op_q;
    logic [SECR_W-1:0] secreg;
    logic              sec_load;

    sfsec_deser #(.OP_W(OP_W)) i_deser (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .si      (si),
        .op_done (op_done),
        .op_word (op_word)
    );

    sfsec_filter i_filter (
        .op     (op_word),
        .in_otp (otp_q),
        .locked (lock_q),
        .busy   (array_busy),
        .allow  (allow)
    );

    // Security register image: strap bit, lock bit, zeros elsewhere.
    always_comb begin
        secreg           = '0;
        secreg[FACT_BIT] = fact_q;
        secreg[LOCK_BIT] = lock_q;
    end

    assign sec_load = op_done && allow && (op_word == OPC_SECREG_RD);

    sfsec_secout #(.REG_W(SECR_W)) i_secout (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .load  (sec_load),
        .value (secreg),
        .so    (so)
    );

    // Register the verdict and apply the state change of an admitted opcode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            otp_q  <= 1'b0;
            lock_q <= 1'b0;
            fact_q <= factory_strap;
            acc_q  <= 1'b0;
            rej_q  <= 1'b0;
            op_q   <= '0;
        end else begin
            acc_q <= op_done && allow;
            rej_q <= op_done && !allow;
            if (op_done)
                op_q <= op_word;
            if (op_done && allow) begin
                case (op_word)
                    OPC_OTP_ENTER: otp_q  <= 1'b1;
                    OPC_OTP_LEAVE: otp_q  <= 1'b0;
                    OPC_SECREG_WR: lock_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign cmd_accept = acc_q;
    assign cmd_reject = rej_q;
    assign cmd_op     = op_q;
    assign otp_space  = otp_q;

endmodule

// File: rtl/sfsec_chk.sv
// sfsec_chk: protocol checker for sfsec_ctrl, attached by bind.
module sfsec_chk
    import sfsec_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n,
    input logic            array_busy,
    input logic            cmd_accept,
    input logic            cmd_reject,
    input logic [OP_W-1:0] cmd_op,
    input logic            otp_space,
    input logic            so,
    input logic            lock_q
);
    p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject));

    p_acc_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |=> !cmd_accept);

    p_rej_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |=> !cmd_reject);

    p_no_verdict_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (!cmd_accept && !cmd_reject));

    p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

    p_mode_change_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (otp_space != $past(otp_space)) |-> cmd_accept);

    p_busy_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && $past(array_busy)) |->
            (cmd_op == OPC_SECREG_RD || cmd_op == OPC_STAT_RD));

    p_locked_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_accept && $past(otp_space) && $past(lock_q)) |->
            (classify(cmd_op) == CLS_READ || classify(cmd_op) == CLS_MODE));

    p_so_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !so);

endmodule

bind sfsec_ctrl sfsec_chk i_sfsec_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .array_busy (array_busy),
    .cmd_accept (cmd_accept),
    .cmd_reject (cmd_reject),
    .cmd_op     (cmd_op),
    .otp_space  (otp_space),
    .so         (so),
    .lock_q     (lock_q)
);

// File: tb/test_sfsec_ctrl.sv
// test_sfsec_ctrl: directed bench, one task per scenario.
module test_sfsec_ctrl;
    import sfsec_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       factory_strap = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       array_busy = 1'b0;
    logic       cmd_accept, cmd_reject, otp_space, so;
    logic [7:0] cmd_op;

    int checks = 0;
    int fails  = 0;

    // Bench model of the state, built from the requirements.
    bit m_otp, m_lock, m_busy;

    localparam int NOPS = 23;
    logic [7:0] ops [NOPS] = '{8'h03, 8'h0B, 8'h05, 8'h9F, 8'h2B, 8'h02, 8'h06,
                               8'h01, 8'h2F, 8'h68, 8'h36, 8'h39, 8'h7E, 8'h98,
                               8'hC7, 8'hD8, 8'h20, 8'h52, 8'hB1, 8'hC1,
                               8'h00, 8'hFF, 8'hAB};

    always #4 clk = ~clk;

    sfsec_ctrl i_sfsec_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .factory_strap (factory_strap),
        .cs_n          (cs_n),
        .si            (si),
        .array_busy    (array_busy),
        .cmd_accept    (cmd_accept),
        .cmd_reject    (cmd_reject),
        .cmd_op        (cmd_op),
        .otp_space     (otp_space),
        .so            (so)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit m_allow(input logic [7:0] op);
        bit rd, md, pr, pg;
        rd = op inside {8'h03, 8'h0B, 8'h05, 8'h9F, 8'h2B};
        md = op inside {8'hB1, 8'hC1};
        pg = op inside {8'h02, 8'h06};
        pr = op inside {8'h01, 8'h2F, 8'h68, 8'h36, 8'h39, 8'h7E, 8'h98,
                        8'hC7, 8'hD8, 8'h20, 8'h52};
        if (!(rd || md || pg || pr)) return 1'b0;      // R10
        if (m_busy) return (op == 8'h2B) || (op == 8'h05); // R7
        if (!m_otp) return 1'b1;                         // R12
        if (!m_lock) return !pr;                         // R4
        return rd || md;                                 // R6
    endfunction

    task automatic do_reset(input bit strap);
        @(negedge clk);
        cs_n = 1'b1; rst_n = 1'b0; factory_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_otp = 0; m_lock = 0;
        @(negedge clk);
        check("R1 accept", {7'b0, cmd_accept}, 8'h00);
        check("R1 reject", {7'b0, cmd_reject}, 8'h00);
        check("R1 otp_space", {7'b0, otp_space}, 8'h00);
        check("R1 so", {7'b0, so}, 8'h00);
    endtask

    // Drive the top n bits of v, cs_n low; the last bit is sampled at the next edge.
    task automatic shift_bits(input logic [7:0] v, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            @(negedge clk);
            cs_n = 1'b0;
            si = v[i];
        end
    endtask

    task automatic issue(input logic [7:0] op, input string req);
        bit exp;
        exp = m_allow(op);
        shift_bits(op, 8);
        @(negedge clk);
        check({req, " R9 accept"}, {7'b0, cmd_accept}, {7'b0, exp});
        check({req, " R9 reject"}, {7'b0, cmd_reject}, {7'b0, !exp});
        check({req, " R9 cmd_op"}, cmd_op, op);
        cs_n = 1'b1; si = 1'b0;
        if (exp) begin
            if (op == 8'hB1) m_otp = 1;
            if (op == 8'hC1) m_otp = 0;
            if (op == 8'h2F) m_lock = 1;
        end
        @(negedge clk);
        check("R2 otp_space", {7'b0, otp_space}, {7'b0, m_otp});
    endtask

    task automatic read_sec(input logic [7:0] exp, input int nbytes);
        bit ok;
        ok = m_allow(8'h2B);
        shift_bits(8'h2B, 8);
        for (int b = 0; b < nbytes * 8; b++) begin
            @(negedge clk);
            if (b == 0) check("R7 R8 read accepted", {7'b0, cmd_accept}, {7'b0, ok});
            si = 1'b1;
            check("R8 so bit", {7'b0, so}, {7'b0, exp[7 - (b % 8)]});
        end
        cs_n = 1'b1; si = 1'b0;
        @(negedge clk);
        check("R8 so idle", {7'b0, so}, 8'h00);
    endtask

    task automatic partial(input logic [7:0] op, input int n);
        bit otp0;
        otp0 = m_otp;
        shift_bits(op, n);
        @(negedge clk);
        cs_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R3 no verdict", {6'b0, cmd_accept, cmd_reject}, 8'h00);
        end
        check("R3 mode kept", {7'b0, otp_space}, {7'b0, otp0});
    endtask

    task automatic trailing();
        shift_bits(8'hB1, 8);
        @(negedge clk);
        check("R11 first verdict", {7'b0, cmd_accept}, 8'h01);
        m_otp = 1;
        for (int i = 7; i >= 0; i--) begin
            si = 8'hC1 >> i;
            @(negedge clk);
            check("R11 no extra verdict", {6'b0, cmd_accept, cmd_reject}, 8'h00);
        end
        cs_n = 1'b1;
        @(negedge clk);
        check("R11 mode kept", {7'b0, otp_space}, 8'h01);
    endtask

    task automatic sweep(input bit want_otp, input bit skip_wr, input string req);
        for (int i = 0; i < NOPS; i++) begin
            if (skip_wr && ops[i] == 8'h2F) continue;
            if (m_otp != want_otp) issue(want_otp ? 8'hB1 : 8'hC1, "R2");
            issue(ops[i], req);
        end
    endtask

    task automatic busy_case();
        array_busy = 1'b1; m_busy = 1;
        read_sec({6'b0, m_lock, 1'b1}, 1);
        issue(8'h05, "R7 status while busy");
        issue(8'h03, "R7 read refused while busy");
        issue(8'hB1, "R7 enter refused while busy");
        issue(8'h2F, "R7 write refused while busy");
        array_busy = 1'b0; m_busy = 0;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_otp = 0; m_lock = 0; m_busy = 0;
        do_reset(1'b1);                       // R1
        read_sec(8'h01, 2);                   // R1 R8 factory bit
        issue(8'h03, "R12 read main");
        issue(8'hB1, "R2 enter");
        issue(8'hC1, "R2 leave");
        partial(8'hB1, 5);                    // R3
        partial(8'hB1, 7);                    // R3
        sweep(1'b0, 1'b1, "R12 R10 main sweep");
        sweep(1'b1, 1'b0, "R4 R10 secure sweep");
        issue(8'hC1, "R2 leave");
        trailing();                           // R11
        issue(8'hC1, "R2 leave");
        busy_case();                          // R7
        issue(8'h2F, "R5 set lock");
        read_sec(8'h03, 2);                   // R5 R8
        sweep(1'b1, 1'b0, "R6 R10 locked sweep");
        sweep(1'b0, 1'b0, "R5 main locked sweep");
        read_sec(8'h03, 1);                   // R5 still set
        do_reset(1'b0);                       // R1
        read_sec(8'h00, 1);                   // R1 strap 0, lock cleared
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule